// File: doc/BRIEF.md
# Programmable Down-Counter Timer Core

This block is a single programmable down-counter. Software-facing logic elsewhere in the chip decodes bus accesses and hands this core one-cycle write strobes with a data word for four targets: the immediate load, the background load, the control word and the interrupt clear. The core counts down on a timer clock enable (`tick_en`), which is divided by a selectable prescaler. It reports its count, its reload value, its control word, a raw interrupt and a masked interrupt.

The counter has three behaviours when it runs out:
- Free-running: it wraps to all-ones of the active width.
- Periodic: it reloads from the reload register.
- One-shot: it halts at zero until it is re-armed.

The count width is 16 or 32 bits and can be changed at run time. In 16-bit mode the upper half of the 32-bit count is held and reported unchanged.

The interfaces are single-cycle strobes and level outputs, so no valid/ready handshake applies and there is no back-pressure. A strobe always takes effect at the next clock edge.

Top module: `dcount_timer_core`

## Requirements
- R1: The control word keeps only bit 0 (one-shot), bit 1 (1 = 32-bit), bits 3:2 (prescale code), bit 5 (interrupt enable), bit 6 (1 = periodic) and bit 7 (enable); every other readback bit is zero, so writing all-ones reads back 0x000000EF.
- R2: Prescale codes 0, 1 and 2 make the count step once per 1, 16 and 256 accepted `tick_en` cycles. Code 3 behaves exactly like code 2. A control write restarts the division.
- R3: In periodic mode, a step taken while the live count is zero reloads it from the reload register (its low 16 bits in 16-bit mode).
- R4: In free-running mode, a step taken at zero wraps the live count to all-ones: 0xFFFF in 16-bit mode and 0xFFFFFFFF in 32-bit mode.
- R5: A LOAD write sets the reload register to the full data word and replaces the count at once. In 16-bit mode only the low 16 bits of the count are replaced.
- R6: A BGLOAD write sets only the reload register; the count is unchanged.
- R7: In 16-bit mode the upper 16 bits of the count never change. Switching between the widths keeps the whole 32-bit count.
- R8: The masked interrupt equals the raw interrupt AND the interrupt enable bit. An INTCLR write clears the raw interrupt one cycle later.
- R9: The raw interrupt sets only when a step takes the live count from 1 to 0. Loading zero, and reloading zero, never set it.
- R10: In one-shot mode the count halts at zero after reaching it. A control write with enable set re-arms it, so the next step reloads or wraps. A nonzero LOAD write while enabled also re-arms it.
- R11: After reset the control readback is 0x20, the count is 0xFFFFFFFF, the reload register is 0 and both interrupts are low.
- R12: With enable clear, `tick_en` does not change the count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_en | input | 1 | Timer clock enable, one per counting opportunity |
| wr_load | input | 1 | Immediate-load write strobe |
| wr_bgload | input | 1 | Background-load write strobe |
| wr_ctrl | input | 1 | Control write strobe |
| wr_intclr | input | 1 | Interrupt clear strobe |
| wr_data | input | 32 | Write data for all strobes |
| count_val | output | 32 | Current 32-bit count |
| load_rd | output | 32 | Reload register readback |
| ctrl_rd | output | 32 | Control readback |
| irq_raw | output | 1 | Raw interrupt |
| irq_masked | output | 1 | Raw interrupt gated by interrupt enable |

## Verification
Every strobe and every counting step is seen at one rising edge. Its effect on the count, the reload register, the control word or the raw interrupt is visible just after that edge. The masked interrupt follows the control word and the raw interrupt combinationally, so it is correct in the same cycle as they are.

The bench drives inputs on the falling edge, holds them for exactly one rising edge, and samples outputs on the following falling edge. Each expected value is therefore taken one edge after its stimulus. Prescaler tests count exact numbers of enable cycles and check the count both one cycle before and on the cycle of the step.

// File: rtl/dcount_pkg.sv
package dcount_pkg;

  // Control word layout; bit positions are software-visible.
  typedef struct packed {
    logic       enable;    // 7
    logic       periodic;  // 6
    logic       irq_en;    // 5
    logic       rsvd4;     // 4
    logic [1:0] prescale;  // 3:2
    logic       wide;      // 1
    logic       oneshot;   // 0
  } ctrl_t;

  localparam int          CTRL_W     = 8;
  localparam logic [7:0]  CTRL_VALID = 8'hEF;
  localparam logic [7:0]  CTRL_RESET = 8'h20;

endpackage

// File: rtl/dcount_ctrl_reg.sv
module dcount_ctrl_reg
  import dcount_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_ctrl,
  input  logic [DATA_W-1:0] wr_data,
  output ctrl_t             ctrl_q
);

  always_ff @(posedge clk) begin
    if (!rst_n)
      ctrl_q <= ctrl_t'(CTRL_RESET);
    else if (wr_ctrl)
      ctrl_q <= ctrl_t'(wr_data[CTRL_W-1:0] & CTRL_VALID);
  end

endmodule

// File: rtl/dcount_prescale.sv
module dcount_prescale #(
  parameter int SH_MID = 4,
  parameter int SH_HI  = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       run,
  input  logic       tick_en,
  input  logic       restart,
  input  logic [1:0] prescale,
  output logic       step
);

  localparam int PW = (SH_HI > 0) ? SH_HI : 1;

  logic [PW-1:0] pcnt_q;
  logic [PW-1:0] term;

  // Code 3 is folded onto code 2 (R2).
  always_comb begin
    unique case (prescale)
      2'd0:    term = '0;
      2'd1:    term = PW'((1 << SH_MID) - 1);
      default: term = PW'((1 << SH_HI) - 1);
    endcase
  end

  assign step = run && tick_en && (pcnt_q == term);

  always_ff @(posedge clk) begin
    if (!rst_n)
      pcnt_q <= '0;
    else if (!run || restart)
      pcnt_q <= '0;
    else if (tick_en)
      pcnt_q <= (pcnt_q == term) ? '0 : pcnt_q + 1'b1;
  end

  // R2
  no_double_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step && prescale != 2'd0 && !restart) |=> !step);

endmodule

// File: rtl/dcount_counter.sv
module dcount_counter
  import dcount_pkg::*;
#(
  parameter int DATA_W   = 32,
  parameter int NARROW_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  ctrl_t             ctrl,
  input  logic              step,
  input  logic              wr_load,
  input  logic              wr_bgload,
  input  logic              wr_ctrl,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] cnt_q,
  output logic [DATA_W-1:0] load_q,
  output logic              run,
  output logic              hit_zero
);

  logic [DATA_W-1:0] cnt_d;
  logic [DATA_W-1:0] reload_val;
  logic              halted_q, halted_d;
  logic              live_zero, live_one, data_nonzero;

  always_comb begin
    if (ctrl.wide) begin
      live_zero    = (cnt_q == '0);
      live_one     = (cnt_q == DATA_W'(1));
      data_nonzero = (wr_data != '0);
    end else begin
      live_zero    = (cnt_q[NARROW_W-1:0] == '0);
      live_one     = (cnt_q[NARROW_W-1:0] == NARROW_W'(1));
      data_nonzero = (wr_data[NARROW_W-1:0] != '0);
    end
  end

  assign reload_val = ctrl.periodic ? load_q : '1;
  assign run        = ctrl.enable && !halted_q;

  // A LOAD write outranks a step in the same cycle.
  always_comb begin
    cnt_d    = cnt_q;
    halted_d = halted_q;
    hit_zero = 1'b0;
    if (wr_load) begin
      if (ctrl.wide) cnt_d = wr_data;
      else           cnt_d[NARROW_W-1:0] = wr_data[NARROW_W-1:0];
      if (ctrl.enable && data_nonzero) halted_d = 1'b0;
    end else if (step) begin
      if (live_zero) begin
        if (ctrl.wide) cnt_d = reload_val;
        else           cnt_d[NARROW_W-1:0] = reload_val[NARROW_W-1:0];
      end else begin
        if (ctrl.wide) cnt_d = cnt_q - DATA_W'(1);
        else           cnt_d[NARROW_W-1:0] = cnt_q[NARROW_W-1:0] - NARROW_W'(1);
        if (live_one) begin
          hit_zero = 1'b1;
          if (ctrl.oneshot) halted_d = 1'b1;
        end
      end
    end
    if (wr_ctrl && wr_data[7]) halted_d = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q    <= '1;
      load_q   <= '0;
      halted_q <= 1'b0;
    end else begin
      cnt_q    <= cnt_d;
      halted_q <= halted_d;
      if (wr_load || wr_bgload) load_q <= wr_data;
    end
  end

  // R10
  halted_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (halted_q && !wr_load && !wr_ctrl) |=> $stable(cnt_q));

  // R7
  upper_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl.wide |=> cnt_q[DATA_W-1:NARROW_W] == $past(cnt_q[DATA_W-1:NARROW_W]));

  // R6
  bgload_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_bgload && !wr_load && !step) |=> $stable(cnt_q));

endmodule

// File: rtl/dcount_irq.sv
module dcount_irq (
  input  logic clk,
  input  logic rst_n,
  input  logic set,
  input  logic clr,
  input  logic irq_en,
  output logic irq_raw,
  output logic irq_masked
);

  // A set in the same cycle as a clear wins.
  always_ff @(posedge clk) begin
    if (!rst_n)     irq_raw <= 1'b0;
    else if (set)   irq_raw <= 1'b1;
    else if (clr)   irq_raw <= 1'b0;
  end

  assign irq_masked = irq_raw && irq_en;

  // R8
  intclr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !set) |=> !irq_raw);

endmodule

// File: rtl/dcount_timer_core.sv
module dcount_timer_core
  import dcount_pkg::*;
#(
  parameter int DATA_W   = 32,
  parameter int NARROW_W = 16,
  parameter int SH_MID   = 4,
  parameter int SH_HI    = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_en,
  input  logic              wr_load,
  input  logic              wr_bgload,
  input  logic              wr_ctrl,
  input  logic              wr_intclr,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] count_val,
  output logic [DATA_W-1:0] load_rd,
  output logic [DATA_W-1:0] ctrl_rd,
  output logic              irq_raw,
  output logic              irq_masked
);

  ctrl_t ctrl_q;
  logic  run, step, hit_zero;

  dcount_ctrl_reg #(.DATA_W(DATA_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .wr_ctrl(wr_ctrl), .wr_data(wr_data),
    .ctrl_q(ctrl_q)
  );

  dcount_prescale #(.SH_MID(SH_MID), .SH_HI(SH_HI)) u_pre (
    .clk(clk), .rst_n(rst_n), .run(run), .tick_en(tick_en),
    .restart(wr_ctrl), .prescale(ctrl_q.prescale), .step(step)
  );

  dcount_counter #(.DATA_W(DATA_W), .NARROW_W(NARROW_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .ctrl(ctrl_q), .step(step),
    .wr_load(wr_load), .wr_bgload(wr_bgload), .wr_ctrl(wr_ctrl),
    .wr_data(wr_data), .cnt_q(count_val), .load_q(load_rd),
    .run(run), .hit_zero(hit_zero)
  );

  dcount_irq u_irq (
    .clk(clk), .rst_n(rst_n), .set(hit_zero), .clr(wr_intclr),
    .irq_en(ctrl_q.irq_en), .irq_raw(irq_raw), .irq_masked(irq_masked)
  );

  assign ctrl_rd = {{(DATA_W-CTRL_W){1'b0}}, ctrl_q};

  // R9
  irq_at_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_raw) |-> count_val[NARROW_W-1:0] == '0);

  // R9
  load_no_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_load |=> !$rose(irq_raw));

endmodule

// File: tb/test_dcount_timer_core.sv
module test_dcount_timer_core;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick_en = 1'b0;
  logic        wr_load = 1'b0, wr_bgload = 1'b0, wr_ctrl = 1'b0, wr_intclr = 1'b0;
  logic [31:0] wr_data = '0;
  logic [31:0] count_val, load_rd, ctrl_rd;
  logic        irq_raw, irq_masked;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  dcount_timer_core i_dcount_timer_core (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en),
    .wr_load(wr_load), .wr_bgload(wr_bgload), .wr_ctrl(wr_ctrl),
    .wr_intclr(wr_intclr), .wr_data(wr_data),
    .count_val(count_val), .load_rd(load_rd), .ctrl_rd(ctrl_rd),
    .irq_raw(irq_raw), .irq_masked(irq_masked)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
    end
  endtask

  // kind: 0 load, 1 bgload, 2 ctrl, 3 intclr
  task automatic wr(input int kind, input logic [31:0] d);
    @(negedge clk);
    wr_data = d;
    wr_load = (kind == 0); wr_bgload = (kind == 1);
    wr_ctrl = (kind == 2); wr_intclr = (kind == 3);
    @(negedge clk);
    wr_load = 0; wr_bgload = 0; wr_ctrl = 0; wr_intclr = 0;
  endtask

  task automatic tick(input int n);
    @(negedge clk);
    tick_en = 1'b1;
    repeat (n) @(negedge clk);
    tick_en = 1'b0;
  endtask

  task automatic t_reset;
    chk("R11 ctrl", ctrl_rd, 32'h20);
    chk("R11 count", count_val, 32'hFFFFFFFF);
    chk("R11 load", load_rd, 32'h0);
    chk("R11 irq", {30'd0, irq_raw, irq_masked}, 32'h0);
  endtask

  task automatic t_ctrl_mask;
    wr(2, 32'hFFFFFFFF);
    chk("R1 mask", ctrl_rd, 32'hEF);
    wr(2, 32'h20);
    chk("R1 restore", ctrl_rd, 32'h20);
  endtask

  task automatic t_disabled;
    tick(5);
    chk("R12 disabled", count_val, 32'hFFFFFFFF);
  endtask

  task automatic t_free16;
    wr(0, 32'h00050003);
    chk("R5 narrow load", count_val, 32'hFFFF0003);
    chk("R5 load reg", load_rd, 32'h00050003);
    chk("R9 load no irq", {31'd0, irq_raw}, 32'h0);
    wr(2, 32'hA0);
    tick(2);
    chk("R4 count", count_val, 32'hFFFF0001);
    tick(1);
    chk("R9 zero", count_val, 32'hFFFF0000);
    chk("R9 raw", {31'd0, irq_raw}, 32'h1);
    chk("R8 masked", {31'd0, irq_masked}, 32'h1);
    tick(1);
    chk("R4 wrap16", count_val, 32'hFFFFFFFF);
    wr(3, 32'h0);
    chk("R8 clear", {30'd0, irq_raw, irq_masked}, 32'h0);
  endtask

  task automatic t_free32;
    wr(2, 32'hA2);
    wr(0, 32'h1);
    tick(1);
    chk("R9 raw32", {31'd0, irq_raw}, 32'h1);
    tick(1);
    chk("R4 wrap32", count_val, 32'hFFFFFFFF);
    wr(3, 32'h0);
  endtask

  task automatic t_periodic;
    wr(2, 32'hE2);
    wr(0, 32'h2);
    tick(1);
    chk("R3 dec", count_val, 32'h1);
    wr(1, 32'h5);
    chk("R6 count kept", count_val, 32'h1);
    chk("R6 load reg", load_rd, 32'h5);
    tick(1);
    chk("R3 zero", count_val, 32'h0);
    tick(1);
    chk("R3 reload", count_val, 32'h5);
    wr(3, 32'h0);
  endtask

  task automatic t_irq_mask;
    wr(2, 32'hC2);
    wr(0, 32'h1);
    tick(1);
    chk("R8 raw on", {31'd0, irq_raw}, 32'h1);
    chk("R8 masked off", {31'd0, irq_masked}, 32'h0);
    wr(2, 32'hE2);
    chk("R8 masked on", {31'd0, irq_masked}, 32'h1);
    wr(3, 32'h0);
    chk("R8 cleared", {31'd0, irq_raw}, 32'h0);
  endtask

  task automatic t_zero_load;
    wr(0, 32'h0);
    chk("R9 zero load", count_val, 32'h0);
    tick(3);
    chk("R9 zero reload", count_val, 32'h0);
    chk("R9 no irq", {31'd0, irq_raw}, 32'h0);
  endtask

  task automatic t_oneshot;
    wr(2, 32'hE3);
    wr(0, 32'h2);
    tick(2);
    chk("R10 reach", count_val, 32'h0);
    tick(4);
    chk("R10 halted", count_val, 32'h0);
    wr(3, 32'h0);
    wr(2, 32'hE3);
    tick(1);
    chk("R10 ctrl rearm", count_val, 32'h2);
    chk("R10 no irq on reload", {31'd0, irq_raw}, 32'h0);
    tick(2);
    tick(2);
    chk("R10 halted again", count_val, 32'h0);
    wr(3, 32'h0);
    wr(0, 32'h3);
    tick(1);
    chk("R10 load rearm", count_val, 32'h2);
  endtask

  task automatic t_width;
    wr(2, 32'hE2);
    wr(0, 32'h12340005);
    wr(2, 32'hE0);
    chk("R7 switch keep", count_val, 32'h12340005);
    tick(1);
    chk("R7 narrow dec", count_val, 32'h12340004);
    wr(1, 32'hABCD0002);
    tick(4);
    chk("R7 narrow zero", count_val, 32'h12340000);
    tick(1);
    chk("R3 narrow reload", count_val, 32'h12340002);
    wr(2, 32'hE2);
    tick(1);
    chk("R7 wide again", count_val, 32'h12340001);
    wr(3, 32'h0);
  endtask

  task automatic t_prescale;
    wr(2, 32'hE6);
    wr(0, 32'd100);
    tick(15);
    chk("R2 div16 hold", count_val, 32'd100);
    tick(1);
    chk("R2 div16 step", count_val, 32'd99);
    tick(16);
    chk("R2 div16 again", count_val, 32'd98);
    wr(2, 32'hEA);
    tick(255);
    chk("R2 div256 hold", count_val, 32'd98);
    tick(1);
    chk("R2 div256 step", count_val, 32'd97);
    wr(2, 32'hEE);
    tick(255);
    chk("R2 code3 hold", count_val, 32'd97);
    tick(1);
    chk("R2 code3 step", count_val, 32'd96);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_ctrl_mask();
    t_disabled();
    t_free16();
    t_free32();
    t_periodic();
    t_irq_mask();
    t_zero_load();
    t_oneshot();
    t_width();
    t_prescale();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule